// File: doc/BRIEF.md
# Multirate Averaging Output Stage

This block sits behind a fast fixed-step numerical solver and turns its per-step results into two outputs at two rates. Each valid solver sample is added into a frame accumulator. When a frame of N valid samples has been collected, the block publishes their arithmetic mean, rounded half away from zero, and holds that value until the next frame closes. A one-clock valid pulse marks every publication. N is taken from a runtime input in the range 1 to 64. Ratios that are not powers of two are handled by multiplying with a reciprocal that is worked out ahead of time, so no iterative divider is needed.

Alongside the average, a sign comparator refreshes on every valid sample. It raises its flag when the sample is greater than or equal to zero. Edge-sensitive logic downstream therefore sees a zero crossing one clock after the sample, without waiting for the end of the slower simulation step.

The frame sequencer has two states. ST_IDLE means no frame is open. ST_ACCUM means a frame is open and still needs samples. The START transition (ST_IDLE to ST_ACCUM) happens on a valid sample when the ratio is above 1. It latches the ratio and loads the sample. The SINGLE transition (ST_IDLE to ST_IDLE) happens on a valid sample when the ratio is 1, and that sample is published on its own. The GATHER transition (ST_ACCUM to ST_ACCUM) adds a sample that is not the last one of the frame. The CLOSE transition (ST_ACCUM to ST_IDLE) adds the last sample, hands the total to the divider and clears the accumulator.

Top module: `multirate_avg_stage`

## Requirements
- R1: One clock after a valid sample, `cmp_flag` is 1 if the sample (two's complement, sign in bit DATA_W-1) is zero or positive, and 0 if it is negative.
- R2: `cmp_flag` keeps its value on every clock without a valid sample.
- R3: One clock after the clock that takes the last sample of a frame, `avg_data` equals the sum of the frame's samples divided by N, rounded half away from zero (for example 2.5 gives 3 and -2.5 gives -3). In that same cycle, `avg_vld` is 1.
- R4: `avg_vld` is high for exactly one clock per published frame. At all other times `avg_data` keeps its last published value.
- R5: Clocks with `samp_vld` low add nothing to a frame and do not count toward N.
- R6: N is latched from `ratio_in` when the first sample of a frame is taken. A change to `ratio_in` in the middle of a frame first applies to the next frame.
- R7: A `ratio_in` value of 0 is treated as 1, and a value above 64 is treated as 64.
- R8: While reset is asserted and after it is released, `avg_data`, `avg_vld` and `cmp_flag` are 0. A frame that was partly collected when reset came is discarded, and framing starts again at the first valid sample after reset.
- R9: 64 samples at full scale (all -32768, or all 32767) average to -32768 and 32767 respectively, with no overflow.
- R10: With N equal to 1 and a valid sample on every clock, every sample is published, one clock after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one solver sample can be accepted per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_vld | input | 1 | Sample strobe, one per solver step |
| samp_data | input | DATA_W | Signed solver sample |
| ratio_in | input | RATIO_W | Samples per simulation step (1 to MAX_RATIO) |
| avg_data | output | DATA_W | Signed mean of the last completed frame |
| avg_vld | output | 1 | One-clock pulse when a new mean is published |
| cmp_flag | output | 1 | 1 when the latest sample is greater than or equal to zero |

## Verification
The comparator result is due one clock after its sample, and the mean is due two edges after the last sample of a frame. One of those edges is the frame's CLOSE and the other is the divider register. The bench drives inputs just after a rising edge and checks outputs at the same point, one edge later. Its reference model marks a publication as pending in the step that takes the last sample, and expects `avg_vld` and the new `avg_data` in the following step. This lines up with the two-register path. Ratio changes are latched in the model at the same point the hardware latches them: when the first sample of a frame is taken.

// File: rtl/avg_stage_pkg.sv
package avg_stage_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } frame_state_t;

    // Reciprocal ceil(2^frac / (2n)) used for rounded division by n
    function automatic longint recip_of(input int n, input int frac);
        longint den;
        den = longint'(2 * n);
        return ((longint'(1) << frac) + den - 1) / den;
    endfunction

endpackage

// File: rtl/avg_sign_cmp.sv
module avg_sign_cmp #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_vld,
    input  logic [DATA_W-1:0] samp_data,
    output logic              cmp_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
        end else if (samp_vld) begin
            cmp_flag <= ~samp_data[DATA_W-1];
        end
    end

endmodule

// File: rtl/avg_frame_ctrl.sv
module avg_frame_ctrl
    import avg_stage_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_RATIO = 64,
    parameter int RATIO_W   = $clog2(MAX_RATIO + 1),
    parameter int ACC_W     = DATA_W + $clog2(MAX_RATIO)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    samp_vld,
    input  logic [DATA_W-1:0]       samp_data,
    input  logic [RATIO_W-1:0]      ratio_in,
    output logic                    fin_vld,
    output logic signed [ACC_W-1:0] fin_sum,
    output logic [RATIO_W-1:0]      fin_n
);

    localparam int EXT_W = ACC_W - DATA_W;

    frame_state_t            state_q, state_d;
    logic signed [ACC_W-1:0] acc_q;
    logic [RATIO_W-1:0]      cnt_q;
    logic [RATIO_W-1:0]      ratio_q;
    logic [RATIO_W-1:0]      ratio_eff;
    logic signed [ACC_W-1:0] samp_ext;
    logic                    last_samp;

    always_comb begin
        if (ratio_in == '0) begin
            ratio_eff = RATIO_W'(1);
        end else if (ratio_in > RATIO_W'(MAX_RATIO)) begin
            ratio_eff = RATIO_W'(MAX_RATIO);
        end else begin
            ratio_eff = ratio_in;
        end
    end

    assign samp_ext  = {{EXT_W{samp_data[DATA_W-1]}}, samp_data};
    assign last_samp = (cnt_q + RATIO_W'(1)) == ratio_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: START, SINGLE, GATHER, CLOSE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (samp_vld && ratio_eff != RATIO_W'(1)) begin
                    state_d = ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                if (samp_vld && last_samp) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            ratio_q <= RATIO_W'(1);
            fin_vld <= 1'b0;
            fin_sum <= '0;
            fin_n   <= RATIO_W'(1);
        end else begin
            fin_vld <= 1'b0;
            if (samp_vld) begin
                unique case (state_q)
                    ST_IDLE: begin
                        ratio_q <= ratio_eff;
                        if (ratio_eff == RATIO_W'(1)) begin
                            fin_vld <= 1'b1;
                            fin_sum <= samp_ext;
                            fin_n   <= RATIO_W'(1);
                            acc_q   <= '0;
                            cnt_q   <= '0;
                        end else begin
                            acc_q <= samp_ext;
                            cnt_q <= RATIO_W'(1);
                        end
                    end
                    ST_ACCUM: begin
                        if (last_samp) begin
                            fin_vld <= 1'b1;
                            fin_sum <= acc_q + samp_ext;
                            fin_n   <= ratio_q;
                            acc_q   <= '0;
                            cnt_q   <= '0;
                        end else begin
                            acc_q <= acc_q + samp_ext;
                            cnt_q <= cnt_q + RATIO_W'(1);
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/avg_recip_div.sv
module avg_recip_div
    import avg_stage_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_RATIO = 64,
    parameter int RATIO_W   = $clog2(MAX_RATIO + 1),
    parameter int ACC_W     = DATA_W + $clog2(MAX_RATIO)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fin_vld,
    input  logic signed [ACC_W-1:0] fin_sum,
    input  logic [RATIO_W-1:0]      fin_n,
    output logic [DATA_W-1:0]       avg_data,
    output logic                    avg_vld
);

    localparam int NUM_W  = ACC_W + 1;
    localparam int FRAC   = NUM_W + 8;
    localparam int RCP_W  = FRAC;
    localparam int PROD_W = NUM_W + RCP_W;

    logic [RCP_W-1:0]  recip_tab [1:MAX_RATIO];
    logic              neg;
    logic [ACC_W-1:0]  mag;
    logic [NUM_W-1:0]  num;
    logic [RCP_W-1:0]  recip;
    logic [PROD_W-1:0] prod;
    logic [DATA_W:0]   quo;
    logic [DATA_W:0]   signed_quo;

    for (genvar g = 1; g <= MAX_RATIO; g++) begin : g_recip
        assign recip_tab[g] = RCP_W'(recip_of(g, FRAC));
    end

    assign neg        = fin_sum[ACC_W-1];
    assign mag        = neg ? ACC_W'(-fin_sum) : ACC_W'(fin_sum);
    assign num        = {mag, 1'b0} + NUM_W'(fin_n);
    assign recip      = recip_tab[fin_n];
    assign prod       = PROD_W'(num) * PROD_W'(recip);
    assign quo        = prod[FRAC +: DATA_W+1];
    assign signed_quo = neg ? -quo : quo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avg_data <= '0;
            avg_vld  <= 1'b0;
        end else begin
            avg_vld <= fin_vld;
            if (fin_vld) begin
                avg_data <= signed_quo[DATA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/multirate_avg_stage.sv
module multirate_avg_stage #(
    parameter int DATA_W    = 16,
    parameter int MAX_RATIO = 64,
    parameter int RATIO_W   = $clog2(MAX_RATIO + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               samp_vld,
    input  logic [DATA_W-1:0]  samp_data,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [DATA_W-1:0]  avg_data,
    output logic               avg_vld,
    output logic               cmp_flag
);

    localparam int ACC_W = DATA_W + $clog2(MAX_RATIO);

    logic                    fin_vld;
    logic signed [ACC_W-1:0] fin_sum;
    logic [RATIO_W-1:0]      fin_n;

    avg_sign_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_vld (samp_vld),
        .samp_data(samp_data),
        .cmp_flag (cmp_flag)
    );

    avg_frame_ctrl #(
        .DATA_W(DATA_W), .MAX_RATIO(MAX_RATIO), .RATIO_W(RATIO_W), .ACC_W(ACC_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_vld (samp_vld),
        .samp_data(samp_data),
        .ratio_in (ratio_in),
        .fin_vld  (fin_vld),
        .fin_sum  (fin_sum),
        .fin_n    (fin_n)
    );

    avg_recip_div #(
        .DATA_W(DATA_W), .MAX_RATIO(MAX_RATIO), .RATIO_W(RATIO_W), .ACC_W(ACC_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .fin_vld (fin_vld),
        .fin_sum (fin_sum),
        .fin_n   (fin_n),
        .avg_data(avg_data),
        .avg_vld (avg_vld)
    );

endmodule

// File: rtl/avg_stage_checker.sv
module avg_stage_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp_vld,
    input logic [DATA_W-1:0] samp_data,
    input logic [DATA_W-1:0] avg_data,
    input logic              avg_vld,
    input logic              cmp_flag
);

    assert_cmp_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld |=> (cmp_flag == !$past(samp_data[DATA_W-1])));

    assert_cmp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld |=> $stable(cmp_flag));

    assert_avg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_vld |-> $stable(avg_data));

    assert_avg_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld |-> $past(samp_vld, 2));

endmodule

bind multirate_avg_stage avg_stage_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp_vld (samp_vld),
    .samp_data(samp_data),
    .avg_data (avg_data),
    .avg_vld  (avg_vld),
    .cmp_flag (cmp_flag)
);

// File: tb/sim_multirate_avg_stage.sv
`timescale 1ns/1ps
module sim_multirate_avg_stage;

    localparam int DW = 16;
    localparam int MR = 64;
    localparam int RW = $clog2(MR + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 samp_vld = 1'b0;
    logic signed [DW-1:0] samp_data = '0;
    logic [RW-1:0]        ratio_in = RW'(1);
    logic [DW-1:0]        avg_data;
    logic                 avg_vld;
    logic                 cmp_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model
    bit     m_in, pend, exp_vld, exp_cmp;
    int     m_cnt, m_n;
    longint m_sum, pend_val, exp_avg;

    always #2.5 clk = ~clk;

    multirate_avg_stage #(.DATA_W(DW), .MAX_RATIO(MR)) u0 (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_data(samp_data),
        .ratio_in(ratio_in), .avg_data(avg_data), .avg_vld(avg_vld), .cmp_flag(cmp_flag)
    );

    function automatic int clamp_ratio(input int r);
        if (r == 0) return 1;
        if (r > MR) return MR;
        return r;
    endfunction

    function automatic longint round_mean(input longint s, input int n);
        longint a, q;
        a = (s < 0) ? -s : s;
        q = (2 * a + n) / (2 * n);
        return (s < 0) ? -q : q;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_in = 0; pend = 0; exp_vld = 0; exp_cmp = 0;
        m_cnt = 0; m_n = 1; m_sum = 0; pend_val = 0; exp_avg = 0;
    endtask

    task automatic cyc(input bit v, input int d);
        int r;
        samp_vld  = v;
        samp_data = DW'(d);
        r = clamp_ratio(int'(ratio_in));
        @(posedge clk);
        #1;
        exp_vld = pend;
        if (pend) exp_avg = pend_val;
        pend = 0;
        if (v) begin
            exp_cmp = (d >= 0);
            if (!m_in) begin
                m_n = r; m_sum = 0; m_cnt = 0; m_in = 1;
            end
            m_sum += d;
            m_cnt++;
            if (m_cnt == m_n) begin
                pend = 1; pend_val = round_mean(m_sum, m_n); m_in = 0;
            end
        end
        chk(avg_vld == exp_vld, "R4 avg_vld", avg_vld, exp_vld);
        chk($signed(avg_data) == exp_avg, "R3 avg_data", $signed(avg_data), exp_avg);
        if (v) chk(cmp_flag == exp_cmp, "R1 cmp_flag", cmp_flag, exp_cmp);
        else   chk(cmp_flag == exp_cmp, "R2 cmp_flag hold", cmp_flag, exp_cmp);
    endtask

    task automatic do_reset();
        samp_vld = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        chk(avg_data == '0, "R8 avg_data reset", avg_data, 0);
        chk(avg_vld == 1'b0, "R8 avg_vld reset", avg_vld, 0);
        chk(cmp_flag == 1'b0, "R8 cmp_flag reset", cmp_flag, 0);
        rst_n = 1;
    endtask

    initial begin
        void'($urandom(32'd20241));
        model_reset();
        #1;
        do_reset();

        // R3 rounding with N=4: 10/4 -> 3, then -10/4 -> -3
        ratio_in = RW'(4);
        cyc(1, 1); cyc(1, 2); cyc(1, 3); cyc(1, 4); cyc(0, 0);
        chk($signed(avg_data) == 3, "R3 half up", $signed(avg_data), 3);
        cyc(1, -1); cyc(1, -2); cyc(1, -3); cyc(1, -4); cyc(0, 0);
        chk($signed(avg_data) == -3, "R3 half away negative", $signed(avg_data), -3);

        // R1 zero gives flag 1
        cyc(1, -7);
        chk(cmp_flag == 1'b0, "R1 negative", cmp_flag, 0);
        cyc(1, 0);
        chk(cmp_flag == 1'b1, "R1 zero", cmp_flag, 1);
        cyc(1, 0); cyc(1, 0); cyc(0, 0);

        // R5 gaps with N=3 (non-power-of-two): 1,1,2 -> 1
        ratio_in = RW'(3);
        cyc(1, 1); cyc(0, 500); cyc(0, -500); cyc(1, 1); cyc(0, 9); cyc(1, 2); cyc(0, 0);
        chk($signed(avg_data) == 1, "R5 gaps ignored", $signed(avg_data), 1);
        cyc(0, 0);
        chk(avg_vld == 1'b0, "R4 single pulse", avg_vld, 0);

        // R6 ratio change mid-frame
        ratio_in = RW'(4);
        cyc(1, 8); cyc(1, 8);
        ratio_in = RW'(2);
        cyc(1, 4); cyc(1, 4); cyc(0, 0);
        chk($signed(avg_data) == 6, "R6 old ratio kept", $signed(avg_data), 6);
        cyc(1, 5); cyc(1, 6); cyc(0, 0);
        chk($signed(avg_data) == 6, "R6 new ratio used", $signed(avg_data), 6);

        // R7 ratio 0 behaves as 1, ratio 100 behaves as 64
        ratio_in = RW'(0);
        cyc(1, -9); cyc(0, 0);
        chk($signed(avg_data) == -9, "R7 ratio zero", $signed(avg_data), -9);
        ratio_in = RW'(100);
        for (int i = 0; i < 64; i++) cyc(1, i);
        cyc(0, 0);
        chk($signed(avg_data) == 32, "R7 ratio clamp", $signed(avg_data), 32);

        // R9 full scale
        ratio_in = RW'(64);
        for (int i = 0; i < 64; i++) cyc(1, -32768);
        cyc(0, 0);
        chk($signed(avg_data) == -32768, "R9 negative full scale", $signed(avg_data), -32768);
        for (int i = 0; i < 64; i++) cyc(1, 32767);
        cyc(0, 0);
        chk($signed(avg_data) == 32767, "R9 positive full scale", $signed(avg_data), 32767);

        // R10 N=1 back-to-back
        ratio_in = RW'(1);
        cyc(1, 11);
        cyc(1, -12);
        chk(avg_vld && $signed(avg_data) == 11, "R10 first", $signed(avg_data), 11);
        cyc(1, 13);
        chk(avg_vld && $signed(avg_data) == -12, "R10 second", $signed(avg_data), -12);
        cyc(0, 0);

        // R8 partial frame discarded on reset
        ratio_in = RW'(4);
        cyc(1, 1000); cyc(1, 1000);
        do_reset();
        cyc(1, 2); cyc(1, 2); cyc(1, 2); cyc(1, 2); cyc(0, 0);
        chk($signed(avg_data) == 2, "R8 partial frame dropped", $signed(avg_data), 2);

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            int d;
            if ($urandom_range(0, 99) < 3) ratio_in = RW'($urandom_range(0, 70));
            case ($urandom_range(0, 9))
                0:       d = -32768;
                1:       d = 32767;
                2:       d = 0;
                default: d = int'($urandom_range(0, 65535)) - 32768;
            endcase
            cyc($urandom_range(0, 99) < 75, d);
        end
        cyc(0, 0); cyc(0, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule